// File: doc/BRIEF.md
# AUX Request Formatter and Reply Parser

This block sits between a display link's transaction layer and the serial side channel engine. A caller presents one request per cycle: a 4-bit command, a 20-bit target address, a payload length and up to sixteen payload bytes. One cycle later the block returns the byte stream that the channel engine must send. It also returns the number of bytes to send, the number of reply bytes to expect, a status code and a flag. The flag tells the engine to append a locally held key after the header. Requests with an unknown command, or whose lengths exceed the channel's 20-byte data window, are refused with a status code and produce no stream.

When the channel engine hands back the reply bytes and their count, the block interprets them using the most recently accepted request. It extracts the 4-bit reply code. For reads it extracts the returned payload. For writes it extracts the count of bytes the far end actually accepted, which may be fewer than requested. Serial encoding, timing and the retry loop belong to other blocks.

Top module: `aux_req_fmt`

## Requirements
- R1: Output byte 0 (fmt_bytes[7:0]) holds the command in bits 7:4 and address bits 19:16 in bits 3:0. Byte 1 holds address 15:8 and byte 2 holds address 7:0. Byte k occupies fmt_bytes[8k+7:8k].
- R2: A nonzero length L puts L-1 in byte 3. A write then carries payload byte i (req_data[8i+7:8i]) in byte 4+i. A zero-length request sends only the three address bytes. Every byte at or beyond fmt_tx_len reads zero.
- R3: A write (command with bit 2 cleared equal to 4'b1000, 4'b0000 or 4'b0010) sends 4+L bytes, or 3 when L is 0, and expects 2 reply bytes.
- R4: A read (command with bit 2 cleared equal to 4'b1001 or 4'b0001) sends 4 bytes, or 3 when L is 0, and expects L+1 reply bytes.
- R5: When the send or expected-reply length would exceed 20, fmt_status is 1 (too large). In that case fmt_tx_len, fmt_rx_len, fmt_key_sel and fmt_bytes are all zero.
- R6: Any other command (bit 2 ignored) gives fmt_status 2 (invalid) with all other format outputs zero. A valid, fitting request gives fmt_status 0.
- R7: fmt_key_sel is 1 only for an accepted request whose command with bit 2 cleared is 4'b1000 and whose address is 20'h68007.
- R8: fmt_valid is high in exactly the cycle after each req_valid cycle. par_valid is high in exactly the cycle after each rsp_valid cycle.
- R9: par_code is bits 7:4 of reply byte 0. After a read, par_count is min(rsp_cnt, L+1)-1. par_bytes byte i is reply byte i+1 for i < par_count, and all other par_bytes are zero.
- R10: After a write, rsp_cnt of 2 or more gives par_count = min(reply byte 1, L). rsp_cnt of 1 gives par_count = L. par_bytes is zero.
- R11: rsp_cnt of 0 or above 20 gives par_status 3 (bad reply) with par_code, par_count and par_bytes zero. Otherwise par_status is 0.
- R12: Replies are parsed against the most recent request accepted with status 0. Refused requests leave that context unchanged. After reset the context is a read of length 0.
- R13: Reset clears fmt_valid, par_valid and all format and parse outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Request command, bit 2 is the continuation flag |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload length in bytes |
| req_data | input | 128 | Write payload, byte i at bits 8i+7:8i |
| fmt_valid | output | 1 | Format result present |
| fmt_status | output | 2 | 0 ok, 1 too large, 2 invalid |
| fmt_bytes | output | 160 | Byte stream to send, byte k at bits 8k+7:8k |
| fmt_tx_len | output | 5 | Number of bytes to send |
| fmt_rx_len | output | 5 | Number of reply bytes to expect |
| fmt_key_sel | output | 1 | Append the local key after the header |
| rsp_valid | input | 1 | Reply present this cycle |
| rsp_cnt | input | 5 | Number of reply bytes received |
| rsp_bytes | input | 160 | Reply bytes, byte k at bits 8k+7:8k |
| par_valid | output | 1 | Parse result present |
| par_status | output | 2 | 0 ok, 3 bad reply size |
| par_code | output | 4 | Reply code |
| par_count | output | 5 | Read payload size or accepted write count |
| par_bytes | output | 152 | Read payload, byte i at bits 8i+7:8i |

## Verification
A wrong command classification or length computation shows up in the very next format result. It appears as a wrong status, send length or expected-reply length, or as stray non-zero bytes past the send length. A corrupted reply context shows up only later, in the parse result of the next reply. So each stream of requests is followed by replies whose counts are checked against the context of the last accepted request. Refused requests are placed between an accepted request and its reply, to show that they leave the context untouched.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;

    localparam int AUX_ADDR_W    = 20;
    localparam int AUX_CMD_W     = 4;
    localparam int AUX_HDR_BYTES = 4;

    localparam logic [AUX_CMD_W-1:0] CMD_CONT_MASK = 4'b1011;
    localparam logic [AUX_CMD_W-1:0] CMD_NAT_WR    = 4'b1000;
    localparam logic [AUX_CMD_W-1:0] CMD_NAT_RD    = 4'b1001;
    localparam logic [AUX_CMD_W-1:0] CMD_BUS_WR    = 4'b0000;
    localparam logic [AUX_CMD_W-1:0] CMD_BUS_RD    = 4'b0001;
    localparam logic [AUX_CMD_W-1:0] CMD_BUS_WSU   = 4'b0010;

    localparam logic [AUX_ADDR_W-1:0] KEY_ADDR_DEF = 20'h68007;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_TOO_BIG   = 2'd1,
        ST_INVALID   = 2'd2,
        ST_BAD_REPLY = 2'd3
    } aux_status_e;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_NONE  = 2'd2
    } aux_kind_e;

    function automatic aux_kind_e aux_classify(input logic [AUX_CMD_W-1:0] cmd);
        aux_kind_e k;
        case (cmd & CMD_CONT_MASK)
            CMD_NAT_WR, CMD_BUS_WR, CMD_BUS_WSU: k = KIND_WRITE;
            CMD_NAT_RD, CMD_BUS_RD:              k = KIND_READ;
            default:                             k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic aux_is_key_write(input logic [AUX_CMD_W-1:0] cmd,
                                              input logic [AUX_ADDR_W-1:0] addr,
                                              input logic [AUX_ADDR_W-1:0] key_addr);
        return ((cmd & CMD_CONT_MASK) == CMD_NAT_WR) && (addr == key_addr);
    endfunction

endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
    import aux_fmt_pkg::*;
#(
    parameter int MAX_XFER = 20,
    parameter int LEN_W    = 5,
    parameter logic [AUX_ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF,
    localparam int PAY_MAX = MAX_XFER - AUX_HDR_BYTES,
    localparam int EXT_W   = LEN_W + 2
) (
    input  logic [AUX_CMD_W-1:0]  cmd,
    input  logic [AUX_ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]      len,
    input  logic [PAY_MAX*8-1:0]  data,
    output aux_status_e           status,
    output logic [LEN_W-1:0]      tx_len,
    output logic [LEN_W-1:0]      rx_len,
    output logic                  key_sel,
    output logic                  is_write,
    output logic [MAX_XFER*8-1:0] bytes
);

    aux_kind_e        kind;
    logic             has_body;
    logic             ok;
    logic             too_big;
    logic [EXT_W-1:0] len_x;
    logic [EXT_W-1:0] tx_x;
    logic [EXT_W-1:0] rx_x;

    always_comb begin
        kind     = aux_classify(cmd);
        has_body = (len != '0);
        len_x    = EXT_W'(len);
        if (kind == KIND_WRITE) begin
            tx_x = has_body ? len_x + EXT_W'(AUX_HDR_BYTES) : EXT_W'(AUX_HDR_BYTES - 1);
            rx_x = EXT_W'(2);
        end else begin
            tx_x = has_body ? EXT_W'(AUX_HDR_BYTES) : EXT_W'(AUX_HDR_BYTES - 1);
            rx_x = len_x + EXT_W'(1);
        end
        too_big = (tx_x > EXT_W'(MAX_XFER)) || (rx_x > EXT_W'(MAX_XFER));
        if (kind == KIND_NONE)
            status = ST_INVALID;
        else if (too_big)
            status = ST_TOO_BIG;
        else
            status = ST_OK;
        ok       = (status == ST_OK);
        tx_len   = ok ? LEN_W'(tx_x) : '0;
        rx_len   = ok ? LEN_W'(rx_x) : '0;
        key_sel  = ok && aux_is_key_write(cmd, addr, KEY_ADDR);
        is_write = (kind == KIND_WRITE);
    end

    // One lane per output byte: header lanes from command, address and
    // length, payload lanes from the write data when inside the length.
    for (genvar k = 0; k < MAX_XFER; k++) begin : g_lane
        logic [7:0] raw;
        if (k == 0) begin : g_b0
            assign raw = {cmd, addr[AUX_ADDR_W-1:16]};
        end else if (k == 1) begin : g_b1
            assign raw = addr[15:8];
        end else if (k == 2) begin : g_b2
            assign raw = addr[7:0];
        end else if (k == 3) begin : g_b3
            assign raw = has_body ? 8'(len - LEN_W'(1)) : 8'h00;
        end else begin : g_pay
            assign raw = (is_write && (int'(len) > (k - AUX_HDR_BYTES)))
                         ? data[8*(k-AUX_HDR_BYTES) +: 8] : 8'h00;
        end
        assign bytes[8*k +: 8] = ok ? raw : 8'h00;
    end

endmodule

// File: rtl/aux_rsp_parse.sv
module aux_rsp_parse
    import aux_fmt_pkg::*;
#(
    parameter int MAX_XFER = 20,
    parameter int LEN_W    = 5,
    localparam int EXT_W   = LEN_W + 2
) (
    input  logic                      ctx_write,
    input  logic [LEN_W-1:0]          ctx_len,
    input  logic [LEN_W-1:0]          cnt,
    input  logic [MAX_XFER*8-1:0]     rbytes,
    output aux_status_e               status,
    output logic [3:0]                code,
    output logic [LEN_W-1:0]          count,
    output logic [(MAX_XFER-1)*8-1:0] payload
);

    logic             bad;
    logic [EXT_W-1:0] cnt_x;
    logic [EXT_W-1:0] exp_x;
    logic [EXT_W-1:0] lim_x;
    logic [7:0]       acc;
    logic [LEN_W-1:0] wr_count;
    logic [LEN_W-1:0] rd_count;

    always_comb begin
        cnt_x  = EXT_W'(cnt);
        bad    = (cnt == '0) || (cnt_x > EXT_W'(MAX_XFER));
        exp_x  = EXT_W'(ctx_len) + EXT_W'(1);
        lim_x  = (cnt_x > exp_x) ? exp_x : cnt_x;
        rd_count = bad ? '0 : LEN_W'(lim_x - EXT_W'(1));
        acc    = rbytes[15:8];
        if (cnt_x >= EXT_W'(2))
            wr_count = (int'(acc) > int'(ctx_len)) ? ctx_len : LEN_W'(acc);
        else
            wr_count = ctx_len;
        status = bad ? ST_BAD_REPLY : ST_OK;
        code   = bad ? 4'h0 : rbytes[7:4];
        if (bad)
            count = '0;
        else if (ctx_write)
            count = wr_count;
        else
            count = rd_count;
    end

    for (genvar i = 0; i < MAX_XFER - 1; i++) begin : g_pay
        assign payload[8*i +: 8] = (!bad && !ctx_write && (int'(count) > i))
                                   ? rbytes[8*(i+1) +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
    import aux_fmt_pkg::*;
#(
    parameter int MAX_XFER = 20,
    parameter int LEN_W    = 5,
    parameter logic [AUX_ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF,
    localparam int PAY_MAX = MAX_XFER - AUX_HDR_BYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [AUX_CMD_W-1:0]      req_cmd,
    input  logic [AUX_ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [PAY_MAX*8-1:0]      req_data,
    output logic                      fmt_valid,
    output logic [1:0]                fmt_status,
    output logic [MAX_XFER*8-1:0]     fmt_bytes,
    output logic [LEN_W-1:0]          fmt_tx_len,
    output logic [LEN_W-1:0]          fmt_rx_len,
    output logic                      fmt_key_sel,
    input  logic                      rsp_valid,
    input  logic [LEN_W-1:0]          rsp_cnt,
    input  logic [MAX_XFER*8-1:0]     rsp_bytes,
    output logic                      par_valid,
    output logic [1:0]                par_status,
    output logic [3:0]                par_code,
    output logic [LEN_W-1:0]          par_count,
    output logic [(MAX_XFER-1)*8-1:0] par_bytes
);

    aux_status_e               b_status;
    logic [LEN_W-1:0]          b_tx_len;
    logic [LEN_W-1:0]          b_rx_len;
    logic                      b_key_sel;
    logic                      b_write;
    logic [MAX_XFER*8-1:0]     b_bytes;

    aux_status_e               p_status;
    logic [3:0]                p_code;
    logic [LEN_W-1:0]          p_count;
    logic [(MAX_XFER-1)*8-1:0] p_bytes;

    logic                      ctx_write;
    logic [LEN_W-1:0]          ctx_len;

    aux_hdr_build #(
        .MAX_XFER (MAX_XFER),
        .LEN_W    (LEN_W),
        .KEY_ADDR (KEY_ADDR)
    ) u_build (
        .cmd      (req_cmd),
        .addr     (req_addr),
        .len      (req_len),
        .data     (req_data),
        .status   (b_status),
        .tx_len   (b_tx_len),
        .rx_len   (b_rx_len),
        .key_sel  (b_key_sel),
        .is_write (b_write),
        .bytes    (b_bytes)
    );

    aux_rsp_parse #(
        .MAX_XFER (MAX_XFER),
        .LEN_W    (LEN_W)
    ) u_parse (
        .ctx_write (ctx_write),
        .ctx_len   (ctx_len),
        .cnt       (rsp_cnt),
        .rbytes    (rsp_bytes),
        .status    (p_status),
        .code      (p_code),
        .count     (p_count),
        .payload   (p_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_valid   <= 1'b0;
            fmt_status  <= ST_OK;
            fmt_bytes   <= '0;
            fmt_tx_len  <= '0;
            fmt_rx_len  <= '0;
            fmt_key_sel <= 1'b0;
            ctx_write   <= 1'b0;
            ctx_len     <= '0;
        end else begin
            fmt_valid <= req_valid;
            if (req_valid) begin
                fmt_status  <= b_status;
                fmt_bytes   <= b_bytes;
                fmt_tx_len  <= b_tx_len;
                fmt_rx_len  <= b_rx_len;
                fmt_key_sel <= b_key_sel;
                if (b_status == ST_OK) begin
                    ctx_write <= b_write;
                    ctx_len   <= req_len;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_valid  <= 1'b0;
            par_status <= ST_OK;
            par_code   <= '0;
            par_count  <= '0;
            par_bytes  <= '0;
        end else begin
            par_valid <= rsp_valid;
            if (rsp_valid) begin
                par_status <= p_status;
                par_code   <= p_code;
                par_count  <= p_count;
                par_bytes  <= p_bytes;
            end
        end
    end

endmodule

// File: rtl/aux_req_fmt_chk.sv
module aux_req_fmt_chk
    import aux_fmt_pkg::*;
#(
    parameter int MAX_XFER = 20,
    parameter int LEN_W    = 5,
    parameter logic [AUX_ADDR_W-1:0] KEY_ADDR = KEY_ADDR_DEF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [AUX_CMD_W-1:0]  req_cmd,
    input logic [AUX_ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]      req_len,
    input logic                  rsp_valid,
    input logic                  fmt_valid,
    input logic [1:0]            fmt_status,
    input logic [MAX_XFER*8-1:0] fmt_bytes,
    input logic [LEN_W-1:0]      fmt_tx_len,
    input logic [LEN_W-1:0]      fmt_rx_len,
    input logic                  fmt_key_sel,
    input logic                  par_valid,
    input logic [1:0]            par_status,
    input logic [3:0]            par_code,
    input logic [LEN_W-1:0]      par_count,
    input logic                  ctx_write,
    input logic [LEN_W-1:0]      ctx_len
);

    AST_FMT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> fmt_valid); // R8
    AST_FMT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !fmt_valid); // R8
    AST_PAR_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> par_valid); // R8
    AST_HDR_ADDR_BYTES: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_status == ST_OK) |->
        fmt_bytes[23:0] == {$past(req_addr[7:0]), $past(req_addr[15:8]),
                            $past(req_cmd), $past(req_addr[19:16])}); // R1
    AST_ZERO_LEN_THREE: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_status == ST_OK && $past(req_len) == '0) |->
        fmt_tx_len == LEN_W'(3)); // R2
    AST_WRITE_RX_TWO: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_status == ST_OK && !$past(req_cmd[0])) |->
        fmt_rx_len == LEN_W'(2)); // R3
    AST_READ_RX_LEN: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_status == ST_OK && $past(req_cmd[0])) |->
        fmt_rx_len == $past(req_len) + LEN_W'(1)); // R4
    AST_REFUSED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_status != ST_OK) |->
        (fmt_tx_len == '0 && fmt_rx_len == '0 && !fmt_key_sel && fmt_bytes == '0)); // R5
    AST_KEY_NATIVE_WR: assert property (@(posedge clk) disable iff (rst)
        (fmt_valid && fmt_key_sel) |->
        (($past(req_cmd) & CMD_CONT_MASK) == CMD_NAT_WR && $past(req_addr) == KEY_ADDR)); // R7
    AST_RD_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        (par_valid && par_status == ST_OK && !$past(ctx_write)) |->
        par_count <= $past(ctx_len)); // R9
    AST_WR_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        (par_valid && par_status == ST_OK && $past(ctx_write)) |->
        par_count <= $past(ctx_len)); // R10
    AST_BAD_REPLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (par_valid && par_status == ST_BAD_REPLY) |->
        (par_count == '0 && par_code == 4'h0)); // R11

endmodule

bind aux_req_fmt aux_req_fmt_chk #(
    .MAX_XFER (MAX_XFER),
    .LEN_W    (LEN_W),
    .KEY_ADDR (KEY_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .rsp_valid   (rsp_valid),
    .fmt_valid   (fmt_valid),
    .fmt_status  (fmt_status),
    .fmt_bytes   (fmt_bytes),
    .fmt_tx_len  (fmt_tx_len),
    .fmt_rx_len  (fmt_rx_len),
    .fmt_key_sel (fmt_key_sel),
    .par_valid   (par_valid),
    .par_status  (par_status),
    .par_code    (par_code),
    .par_count   (par_count),
    .ctx_write   (ctx_write),
    .ctx_len     (ctx_len)
);

// File: tb/test_aux_req_fmt.sv
module test_aux_req_fmt;
    import aux_fmt_pkg::*;

    localparam int MAX_XFER = 20;
    localparam int LEN_W    = 5;
    localparam int TX_W     = MAX_XFER * 8;
    localparam int PAY_W    = (MAX_XFER - 4) * 8;
    localparam int RPL_W    = (MAX_XFER - 1) * 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [3:0]        req_cmd = '0;
    logic [19:0]       req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [PAY_W-1:0]  req_data = '0;
    logic              fmt_valid;
    logic [1:0]        fmt_status;
    logic [TX_W-1:0]   fmt_bytes;
    logic [LEN_W-1:0]  fmt_tx_len;
    logic [LEN_W-1:0]  fmt_rx_len;
    logic              fmt_key_sel;
    logic              rsp_valid = 1'b0;
    logic [LEN_W-1:0]  rsp_cnt = '0;
    logic [TX_W-1:0]   rsp_bytes = '0;
    logic              par_valid;
    logic [1:0]        par_status;
    logic [3:0]        par_code;
    logic [LEN_W-1:0]  par_count;
    logic [RPL_W-1:0]  par_bytes;

    always #10 clk = ~clk;

    aux_req_fmt #(.MAX_XFER(MAX_XFER), .LEN_W(LEN_W)) i_aux_req_fmt (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_len(req_len), .req_data(req_data),
        .fmt_valid(fmt_valid), .fmt_status(fmt_status), .fmt_bytes(fmt_bytes),
        .fmt_tx_len(fmt_tx_len), .fmt_rx_len(fmt_rx_len), .fmt_key_sel(fmt_key_sel),
        .rsp_valid(rsp_valid), .rsp_cnt(rsp_cnt), .rsp_bytes(rsp_bytes),
        .par_valid(par_valid), .par_status(par_status), .par_code(par_code),
        .par_count(par_count), .par_bytes(par_bytes)
    );

    typedef struct packed {
        logic [1:0]       st;
        logic [LEN_W-1:0] tx;
        logic [LEN_W-1:0] rx;
        logic             key;
        logic [TX_W-1:0]  b;
    } fmt_exp_t;

    typedef struct packed {
        logic [1:0]       st;
        logic [3:0]       code;
        logic [LEN_W-1:0] cnt;
        logic [RPL_W-1:0] b;
    } par_exp_t;

    fmt_exp_t fmt_q[$];
    string    fmt_tag_q[$];
    par_exp_t par_q[$];
    string    par_tag_q[$];

    int checks = 0;
    int errors = 0;

    // reference context of the last accepted request
    bit m_write = 1'b0;
    int m_len   = 0;

    function automatic fmt_exp_t model_req(input logic [3:0] cmd, input logic [19:0] addr,
                                           input int len, input logic [PAY_W-1:0] data,
                                           output bit ok, output bit wr);
        fmt_exp_t e;
        logic [3:0] m;
        bit rd;
        int txl, rxl;
        e  = '0;
        ok = 1'b0;
        m  = cmd & 4'b1011;
        wr = (m == 4'b1000) || (m == 4'b0000) || (m == 4'b0010);
        rd = (m == 4'b1001) || (m == 4'b0001);
        if (!wr && !rd) begin
            e.st = 2'd2;
            return e;
        end
        if (wr) begin
            txl = (len == 0) ? 3 : 4 + len;
            rxl = 2;
        end else begin
            txl = (len == 0) ? 3 : 4;
            rxl = len + 1;
        end
        if (txl > 20 || rxl > 20) begin
            e.st = 2'd1;
            return e;
        end
        ok    = 1'b1;
        e.tx  = LEN_W'(txl);
        e.rx  = LEN_W'(rxl);
        e.key = (m == 4'b1000) && (addr == 20'h68007);
        e.b[7:0]   = {cmd, addr[19:16]};
        e.b[15:8]  = addr[15:8];
        e.b[23:16] = addr[7:0];
        if (len != 0) e.b[31:24] = 8'(len - 1);
        if (wr) for (int i = 0; i < len; i++) e.b[32 + 8*i +: 8] = data[8*i +: 8];
        return e;
    endfunction

    function automatic par_exp_t model_rsp(input int cnt, input logic [TX_W-1:0] rb);
        par_exp_t e;
        int n;
        e = '0;
        if (cnt == 0 || cnt > 20) begin
            e.st = 2'd3;
            return e;
        end
        e.code = rb[7:4];
        if (m_write) begin
            if (cnt >= 2) n = (int'(rb[15:8]) > m_len) ? m_len : int'(rb[15:8]);
            else          n = m_len;
        end else begin
            n = ((cnt > m_len + 1) ? m_len + 1 : cnt) - 1;
            for (int i = 0; i < n; i++) e.b[8*i +: 8] = rb[8*(i+1) +: 8];
        end
        e.cnt = LEN_W'(n);
        return e;
    endfunction

    function automatic logic [TX_W-1:0] ramp(input logic [7:0] first);
        logic [TX_W-1:0] r;
        for (int k = 0; k < MAX_XFER; k++) r[8*k +: 8] = first + 8'(k);
        return r;
    endfunction

    task automatic do_req(input string tag, input logic [3:0] cmd, input logic [19:0] addr,
                          input int len, input logic [PAY_W-1:0] data);
        bit ok, wr;
        fmt_exp_t e;
        e = model_req(cmd, addr, len, data, ok, wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = addr;
        req_len   = LEN_W'(len);
        req_data  = data;
        fmt_q.push_back(e);
        fmt_tag_q.push_back(tag);
        if (ok) begin
            m_write = wr;
            m_len   = len;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        checks++;
        if (fmt_q.size() != 0) begin
            errors++;
            $display("FAIL R8 format result missing one cycle after request: pending %0d expected 0",
                     fmt_q.size());
            fmt_q.delete();
            fmt_tag_q.delete();
        end
    endtask

    task automatic do_rsp(input string tag, input int cnt, input logic [TX_W-1:0] rb);
        par_exp_t e;
        e = model_rsp(cnt, rb);
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_cnt   = LEN_W'(cnt);
        rsp_bytes = rb;
        par_q.push_back(e);
        par_tag_q.push_back(tag);
        @(negedge clk);
        rsp_valid = 1'b0;
        #1;
        checks++;
        if (par_q.size() != 0) begin
            errors++;
            $display("FAIL R8 parse result missing one cycle after reply: pending %0d expected 0",
                     par_q.size());
            par_q.delete();
            par_tag_q.delete();
        end
    endtask

    fmt_exp_t mon_f;
    string    mon_ft;
    par_exp_t mon_p;
    string    mon_pt;

    // monitor: pops the expected item whenever the design presents a result
    always @(negedge clk) begin
        if (!rst && fmt_valid) begin
            checks++;
            if (fmt_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected fmt_valid: actual 1 expected 0");
            end else begin
                mon_f  = fmt_q.pop_front();
                mon_ft = fmt_tag_q.pop_front();
                if ({fmt_status, fmt_tx_len, fmt_rx_len, fmt_key_sel, fmt_bytes} !== mon_f) begin
                    errors++;
                    $display("FAIL %s format: actual st=%0d tx=%0d rx=%0d key=%0d bytes=%h expected st=%0d tx=%0d rx=%0d key=%0d bytes=%h",
                             mon_ft, fmt_status, fmt_tx_len, fmt_rx_len, fmt_key_sel, fmt_bytes,
                             mon_f.st, mon_f.tx, mon_f.rx, mon_f.key, mon_f.b);
                end
            end
        end
        if (!rst && par_valid) begin
            checks++;
            if (par_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected par_valid: actual 1 expected 0");
            end else begin
                mon_p  = par_q.pop_front();
                mon_pt = par_tag_q.pop_front();
                if ({par_status, par_code, par_count, par_bytes} !== mon_p) begin
                    errors++;
                    $display("FAIL %s parse: actual st=%0d code=%h cnt=%0d bytes=%h expected st=%0d code=%h cnt=%0d bytes=%h",
                             mon_pt, par_status, par_code, par_count, par_bytes,
                             mon_p.st, mon_p.code, mon_p.cnt, mon_p.b);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state at the ports
        checks++;
        if (fmt_valid !== 1'b0 || par_valid !== 1'b0 || fmt_tx_len !== '0 || fmt_rx_len !== '0 ||
            fmt_bytes !== '0 || fmt_key_sel !== 1'b0 || par_count !== '0 || par_bytes !== '0) begin
            errors++;
            $display("FAIL R13 reset outputs: actual fv=%0d pv=%0d tx=%0d rx=%0d cnt=%0d expected all zero",
                     fmt_valid, par_valid, fmt_tx_len, fmt_rx_len, par_count);
        end

        // R12: context after reset is a read of length 0
        do_rsp("R12", 1, 160'h90);

        // R1 / R4 / R9: native read of 4 bytes and its replies
        do_req("R1", 4'b1001, 20'h5A3C1, 4, '0);
        do_rsp("R9", 5, 160'h44332211_00);
        do_rsp("R9", 8, 160'h776655_44332211_20);
        do_rsp("R9", 3, 160'h44332211_00);
        do_req("R1", 4'b1001, 20'hFFFFF, 1, '0);

        // R2 / R3 / R10: native write of 3 bytes, extra data byte must not leak
        do_req("R2", 4'b1000, 20'h00102, 3, 128'hDDCCBBAA);
        do_rsp("R10", 2, 160'h0210);
        do_rsp("R10", 2, 160'h0900);
        do_rsp("R10", 1, 160'h00);

        // R3 / R4 zero length forms, continuation bit set on the write
        do_req("R3", 4'b0100, 20'h00050, 0, '0);
        do_req("R4", 4'b0001, 20'h00050, 0, '0);

        // R3 / R4 / R5 length boundaries
        do_req("R3", 4'b1000, 20'h00200, 16, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
        do_req("R5", 4'b1000, 20'h00200, 17, '1);
        do_req("R4", 4'b1001, 20'h00300, 19, '0);
        do_req("R5", 4'b1001, 20'h00300, 20, '0);
        do_req("R5", 4'b0001, 20'h00300, 31, '0);

        // R12: refused requests left the read-of-19 context in place
        do_rsp("R12", 20, ramp(8'h30));

        // R6: command classification, continuation bit ignored
        do_req("R6", 4'b0011, 20'h00010, 1, '0);
        do_req("R6", 4'b1010, 20'h00010, 1, '0);
        do_req("R6", 4'b1111, 20'h00010, 1, '0);
        do_req("R6", 4'b1110, 20'h68007, 1, '0);
        do_req("R6", 4'b0110, 20'h00070, 1, 128'h5E);
        do_req("R6", 4'b1101, 20'h00070, 2, '0);

        // R7: key-select flag
        do_req("R7", 4'b1100, 20'h68007, 5, 128'h1122334455);
        do_req("R7", 4'b1000, 20'h68007, 0, '0);
        do_req("R7", 4'b0000, 20'h68007, 5, 128'h1122334455);
        do_req("R7", 4'b1001, 20'h68007, 5, '0);
        do_req("R7", 4'b1000, 20'h68006, 1, 128'h77);

        // R11: illegal reply sizes; R10 against the last write of 1 byte
        do_rsp("R11", 0, ramp(8'h10));
        do_rsp("R11", 21, ramp(8'h10));
        do_rsp("R11", 31, ramp(8'h10));
        do_rsp("R10", 2, 160'h0530);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule